// File: doc/BRIEF.md
# Timed Configuration Readback Arming Unit

This unit sits next to the program-memory read path of a small processor. Software arms it by writing a control register with two bits set together: a self-program enable bit and a readback arm bit. For a short window after that write, a program-memory load does not return flash contents. It returns a configuration byte instead. The 16-bit pointer chooses the byte: one address gives the protection bits and another gives the low fuse byte. The unit drives a select for the processor's read-data multiplexer, along with the byte to place on it.

The arming clears itself. A load that falls inside the load window consumes the arming. A store to program memory inside the longer store window also consumes it. If neither happens, the arming lapses at the end of the store window. While a non-volatile data write is in progress, control writes are refused. Flash erase and programming, and the processor itself, lie outside this unit.

The state machine has three states: `S_IDLE`, `S_LDWIN` (load window open, counter 1..LD_WIN) and `S_STWIN` (load window closed, store window still open).

Its transitions are named as follows:
- ARM (`S_IDLE`→`S_LDWIN` on an accepted control write)
- READ (`S_LDWIN`→`S_IDLE` on a load)
- STORE (`S_LDWIN`/`S_STWIN`→`S_IDLE` on a store)
- LD_EXPIRE (`S_LDWIN`→`S_STWIN` after counter value LD_WIN)
- ST_EXPIRE (`S_STWIN`→`S_IDLE` after counter value ST_WIN)
- TICK (counter advance within a state)

Top module: `cfg_readback_ctl`

## Requirements
- R1: After reset, `cfg_sel` is 0 and `ctl_rdata` is 0x00.
- R2: A control write arms the unit only when bit 0 (enable) and bit 3 (arm) of `ctl_wdata` are both 1. A write lacking either bit has no effect. While the unit is armed, `ctl_rdata` reads 0x09; otherwise it reads 0x00.
- R3: Cycle 1 is the cycle after the arming write's clock edge. A load (`ld_pm`) in cycle 1, 2 or 3 raises `cfg_sel` in that same cycle.
- R4: `cfg_data` returns 0xC0 OR'd with the 6 protection bits (which sit in bits 5:0) when `zptr` is 0x0001. It returns `fuse_lo` when `zptr` is 0x0000, and 0xFF for any other pointer. An armed load with another pointer still raises `cfg_sel` and consumes the arming.
- R5: A load accepted inside the window disarms the unit from the next cycle on. Any later load gives `cfg_sel` = 0.
- R6: A load in cycle 4 or later gives `cfg_sel` = 0.
- R7: A store (`st_pm`) in cycles 1..4 disarms the unit from the next cycle on. Without any load or store, the unit is disarmed from cycle 5.
- R8: A control write while `ee_busy` is 1 is ignored. `ctl_rdata` stays 0x00 and a following load gives `cfg_sel` = 0.
- R9: Control writes made while the unit is armed are ignored. They do not restart the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ld_pm | input | 1 | Decoded program-memory load strobe |
| st_pm | input | 1 | Decoded program-memory store strobe |
| zptr | input | 16 | Pointer register value |
| ee_busy | input | 1 | Non-volatile data write in progress |
| fuse_lo | input | 8 | Low fuse byte |
| lock_bits | input | 6 | Protection bits |
| cfg_sel | output | 1 | Selects `cfg_data` in place of flash data |
| cfg_data | output | 8 | Configuration byte for the read path |
| ctl_rdata | output | 8 | Control register readback |

## Verification
The timing of each result is fixed:
- `cfg_sel` and `cfg_data` are combinational, so they answer a load in the same cycle it is presented.
- `ctl_rdata` changes one cycle after the clock edge that captures an accepted write.
- Disarming after a read, a store or a deadline shows one cycle after that edge.

The bench drives inputs just after each rising edge. It updates a behavioural model with integer counters on the same rising edge, and compares all three outputs at every falling edge. Because of this, a window check lands exactly on cycle 3 or 4, as the requirement defines it.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LDWIN = 2'd1,
        S_STWIN = 2'd2
    } arm_state_t;
endpackage

// File: rtl/cfgrd_decode.sv
module cfgrd_decode #(
    parameter int REG_W   = 8,
    parameter int EN_BIT  = 0,
    parameter int ARM_BIT = 3
) (
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             ee_busy,
    input  logic             armed,
    output logic             arm_req,
    output logic [REG_W-1:0] ctl_rdata
);
    localparam logic [REG_W-1:0] ARM_MASK =
        REG_W'((1 << EN_BIT) | (1 << ARM_BIT));

    // Both bits in one write, refused while a data write is pending.
    always_comb begin
        arm_req   = ctl_wr && !ee_busy && ((ctl_wdata & ARM_MASK) == ARM_MASK);
        ctl_rdata = armed ? ARM_MASK : '0;
    end
endmodule

// File: rtl/cfgrd_fsm.sv
module cfgrd_fsm
    import cfgrd_pkg::*;
#(
    parameter int LD_WIN = 3,
    parameter int ST_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic ld_pm,
    input  logic st_pm,
    output logic armed,
    output logic cfg_sel
);
    localparam int CNT_W = $clog2(ST_WIN + 1);
    localparam logic [CNT_W-1:0] LD_LAST = CNT_W'(LD_WIN);
    localparam logic [CNT_W-1:0] ST_LAST = CNT_W'(ST_WIN);

    arm_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (arm_req) begin              // ARM
                    state_d = S_LDWIN;
                    cnt_d   = CNT_W'(1);
                end
            end
            S_LDWIN: begin
                if (ld_pm || st_pm) begin       // READ / STORE
                    state_d = S_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LD_LAST) begin  // LD_EXPIRE
                    state_d = S_STWIN;
                    cnt_d   = cnt_q + 1'b1;
                end else begin                  // TICK
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            S_STWIN: begin
                if (st_pm || cnt_q == ST_LAST) begin  // STORE / ST_EXPIRE
                    state_d = S_IDLE;
                    cnt_d   = '0;
                end else begin                  // TICK
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = S_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        armed   = (state_q != S_IDLE);
        cfg_sel = (state_q == S_LDWIN) && ld_pm;
    end

    a_r2_arm_starts_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && arm_req) |=> (state_q == S_LDWIN && cnt_q == CNT_W'(1)));
    a_r5_read_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |=> !armed);
    a_r7_store_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && st_pm) |=> !armed);
    a_r7_window_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STWIN && cnt_q == ST_LAST) |=> !armed);
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !ld_pm && !st_pm && cnt_q < ST_LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cfgrd_mux.sv
module cfgrd_mux #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 16,
    parameter int LOCK_W = 6,
    parameter logic [PTR_W-1:0] FUSE_ADDR = 16'h0000,
    parameter logic [PTR_W-1:0] LOCK_ADDR = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic [PTR_W-1:0]  zptr,
    input  logic [DATA_W-1:0] fuse_lo,
    input  logic [LOCK_W-1:0] lock_bits,
    output logic [DATA_W-1:0] cfg_data
);
    localparam int PAD_W = DATA_W - LOCK_W;

    logic [DATA_W-1:0] lock_byte;

    generate
        if (PAD_W > 0) begin : g_pad
            assign lock_byte = {{PAD_W{1'b1}}, lock_bits};
            a_r4_lock_pad_ones: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_sel && zptr == LOCK_ADDR) |-> (&cfg_data[DATA_W-1:LOCK_W]));
        end else begin : g_full
            assign lock_byte = lock_bits;
        end
    endgenerate

    always_comb begin
        if (zptr == LOCK_ADDR)      cfg_data = lock_byte;
        else if (zptr == FUSE_ADDR) cfg_data = fuse_lo;
        else                        cfg_data = '1;
    end
endmodule

// File: rtl/cfg_readback_ctl.sv
module cfg_readback_ctl #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 16,
    parameter int LOCK_W = 6,
    parameter int LD_WIN = 3,
    parameter int ST_WIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              ld_pm,
    input  logic              st_pm,
    input  logic [PTR_W-1:0]  zptr,
    input  logic              ee_busy,
    input  logic [DATA_W-1:0] fuse_lo,
    input  logic [LOCK_W-1:0] lock_bits,
    output logic              cfg_sel,
    output logic [DATA_W-1:0] cfg_data,
    output logic [DATA_W-1:0] ctl_rdata
);
    logic arm_req;
    logic armed;

    cfgrd_decode #(.REG_W(DATA_W), .EN_BIT(0), .ARM_BIT(3)) u_decode (
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ee_busy   (ee_busy),
        .armed     (armed),
        .arm_req   (arm_req),
        .ctl_rdata (ctl_rdata)
    );

    cfgrd_fsm #(.LD_WIN(LD_WIN), .ST_WIN(ST_WIN)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_req (arm_req),
        .ld_pm   (ld_pm),
        .st_pm   (st_pm),
        .armed   (armed),
        .cfg_sel (cfg_sel)
    );

    cfgrd_mux #(.DATA_W(DATA_W), .PTR_W(PTR_W), .LOCK_W(LOCK_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_sel   (cfg_sel),
        .zptr      (zptr),
        .fuse_lo   (fuse_lo),
        .lock_bits (lock_bits),
        .cfg_data  (cfg_data)
    );

    a_r8_busy_blocks_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && ctl_wr && ee_busy) |=> !armed);
endmodule

// File: tb/test_cfg_readback_ctl.sv
module test_cfg_readback_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic        ld_pm = 1'b0;
    logic        st_pm = 1'b0;
    logic [15:0] zptr = 16'h0000;
    logic        ee_busy = 1'b0;
    logic [7:0]  fuse_lo = 8'h62;
    logic [5:0]  lock_bits = 6'b101010;
    logic        cfg_sel;
    logic [7:0]  cfg_data;
    logic [7:0]  ctl_rdata;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    m_armed = 1'b0;
    int    m_since = 0;

    always #2.5 clk = ~clk;

    cfg_readback_ctl i_cfg_readback_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ld_pm(ld_pm), .st_pm(st_pm), .zptr(zptr), .ee_busy(ee_busy),
        .fuse_lo(fuse_lo), .lock_bits(lock_bits), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .ctl_rdata(ctl_rdata)
    );

    // Behavioural reference: armed flag plus cycles since the arming write.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_armed = 1'b0;
            m_since = 0;
        end else if (m_armed) begin
            if ((m_since <= 3 && ld_pm) || st_pm) m_armed = 1'b0;
            else begin
                m_since = m_since + 1;
                if (m_since > 4) m_armed = 1'b0;
            end
        end else if (ctl_wr && !ee_busy && ctl_wdata[0] && ctl_wdata[3]) begin
            m_armed = 1'b1;
            m_since = 1;
        end
    end

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic       e_sel;
        logic [7:0] e_data;
        e_sel  = m_armed && m_since <= 3 && ld_pm;
        e_data = (zptr == 16'h0001) ? {2'b11, lock_bits} :
                 (zptr == 16'h0000) ? fuse_lo : 8'hFF;
        check("cfg_sel", {7'd0, cfg_sel}, {7'd0, e_sel});
        check("cfg_data", cfg_data, e_data);
        check("ctl_rdata", ctl_rdata, m_armed ? 8'h09 : 8'h00);
    end

    task automatic drive(bit wr, logic [7:0] wd, bit ld, bit st, logic [15:0] z, bit busy);
        @(posedge clk);
        #1;
        ctl_wr = wr; ctl_wdata = wd; ld_pm = ld; st_pm = st; zptr = z; ee_busy = busy;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 8'h00, 0, 0, 16'h0000, 0);
    endtask

    task automatic arm();
        drive(1, 8'h09, 0, 0, 16'h0000, 0);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R1";                       // R1 reset state
        idle(4);
        rst_n = 1'b1;
        idle(2);
        cur_req = "R2";                       // R2 partial writes do not arm
        drive(1, 8'h01, 0, 0, 16'h0000, 0);
        drive(1, 8'h08, 0, 0, 16'h0000, 0);
        drive(0, 8'h00, 1, 0, 16'h0000, 0);
        idle(2);
        cur_req = "R3";                       // R3/R4 lock bits at cycle 2
        arm();
        idle(1);
        drive(0, 8'h00, 1, 0, 16'h0001, 0);
        idle(2);
        cur_req = "R4";                       // R4 fuse byte at cycle 3 (window edge)
        arm();
        idle(2);
        drive(0, 8'h00, 1, 0, 16'h0000, 0);
        idle(2);
        lock_bits = 6'b010101; fuse_lo = 8'hA7;
        arm();                                // R4 other pointer -> 0xFF, consumes arming
        drive(0, 8'h00, 1, 0, 16'h1234, 0);
        drive(0, 8'h00, 1, 0, 16'h0001, 0);
        idle(2);
        cur_req = "R5";                       // R5 second load after a read is normal
        arm();
        drive(0, 8'h00, 1, 0, 16'h0001, 0);
        drive(0, 8'h00, 1, 0, 16'h0000, 0);
        idle(2);
        cur_req = "R6";                       // R6 load at cycle 4
        arm();
        idle(3);
        drive(0, 8'h00, 1, 0, 16'h0001, 0);
        idle(2);
        cur_req = "R7";                       // R7 store at cycle 4, then lapse
        arm();
        idle(3);
        drive(0, 8'h00, 0, 1, 16'h0000, 0);
        idle(2);
        arm();
        idle(6);
        arm();                                // R7 store at cycle 1 blocks load at cycle 2
        drive(0, 8'h00, 0, 1, 16'h0000, 0);
        drive(0, 8'h00, 1, 0, 16'h0001, 0);
        idle(2);
        cur_req = "R8";                       // R8 busy write refused
        drive(1, 8'h09, 0, 0, 16'h0000, 1);
        drive(0, 8'h00, 1, 0, 16'h0001, 1);
        drive(0, 8'h00, 1, 0, 16'h0000, 0);
        idle(2);
        cur_req = "R9";                       // R9 rewrite while armed does not restart
        arm();
        idle(1);
        drive(1, 8'h09, 0, 0, 16'h0000, 0);
        drive(0, 8'h00, 0, 0, 16'h0000, 0);
        drive(0, 8'h00, 1, 0, 16'h0000, 0);
        idle(3);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule